// File: doc/BRIEF.md
# Zero-Data Automatic Mute Controller

This block sits beside a stereo serial audio receiver and decides when the left and right output channels must be silenced. It samples the serial data line on rising edges of the bit clock. It treats each full period of the word-select (left/right) clock as one frame. It watches for long stretches in which the data line never changes level. When such a stretch is long enough, it raises an automatic mute on both channels. It drops that mute the moment a differing bit arrives.

The word-select, bit clock and data lines are asynchronous to the block. All three are brought into the master clock domain through a short synchronizer, and bit-clock rising edges are found there. An active-low enable gates the automatic path. Each channel also has its own active-low manual mute pin. Each registered output is active high and is the OR of the automatic mute and that channel's manual mute. The manual and enable pins are treated as quasi-static control levels and are not synchronized.

Top module: `zero_mute_ctrl`

## Requirements
- R1: A synchronous active-high reset clears both outputs, the run count and the frame tracking. After reset is released, the outputs stay low until a new qualifying run builds up or a manual mute is applied.
- R2: Frames run from one rising edge of `lrck` to the next. A frame is quiet when every bit sampled on rising `sclk` edges within it has the same level. Once `MUTE_FRAMES` quiet frames at that level have completed back to back, both outputs go high. One frame fewer leaves them low.
- R3: A run of all-ones frames triggers the mute exactly as a run of all-zeros frames does.
- R4: While `auto_en_n` is high, the automatic path never drives an output high. Driving it low while the run count is already at the limit raises the outputs on the next `mclk` edge. Driving it high again clears them on the next edge.
- R5: While a run is being counted or the mute is active, a sampled bit that differs from the run level clears the count at once. This happens mid-frame, without waiting for the frame to end.
- R6: A quiet frame whose level differs from the previous quiet frame starts a new run of length one. A switch from all zeros to all ones therefore needs a full `MUTE_FRAMES` run of ones.
- R7: Driving `mute_l_n` low forces `mute_l` high on the next `mclk` edge and leaves `mute_r` unaffected.
- R8: Driving `mute_r_n` low forces `mute_r` high on the next `mclk` edge and leaves `mute_l` unaffected.
- R9: The run count saturates at `MUTE_FRAMES`, so an arbitrarily long quiet run keeps the mute asserted.
- R10: A frame whose left half and right half carry different constant levels is not quiet, and repeating such frames never mutes.
- R11: `sclk`, `lrck` and `sdata` pass through `SYNC_STAGES` (default 2) flip-flops on `mclk`. A bit is taken when the synchronized `sclk` goes from 0 to 1. The run count changes only on those edges. The outputs are registered on `mclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; every register runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial bit clock; data is taken on its rising edge |
| lrck | input | 1 | Word-select clock; a rising edge starts a frame |
| sdata | input | 1 | Serial audio data line |
| auto_en_n | input | 1 | Active-low enable of automatic muting |
| mute_l_n | input | 1 | Active-low manual mute, left channel |
| mute_r_n | input | 1 | Active-low manual mute, right channel |
| mute_l | output | 1 | Active-high left channel mute |
| mute_r | output | 1 | Active-high right channel mute |

## Verification
The bench probes the count boundary. It checks that `MUTE_FRAMES` frames still leave the outputs low and that the next frame mutes, which catches an off-by-one that would mute a frame early or late. It checks the zero-to-one level switch, which a design comparing only against "constant within the frame" would wrongly keep counting. It also checks frames whose two halves differ, which a design judging each half separately would treat as quiet. Long runs expose a counter that wraps and drops the mute. A single stray bit in a muted stream, together with the per-cycle model comparison, exposes a release that waits for the frame end or a mute that clears one cycle off.

// File: rtl/zmute_pkg.sv
package zmute_pkg;

    // One synchronized serial event: strobe on bit-clock rise, plus line levels.
    typedef struct packed {
        logic stb;
        logic lrck;
        logic dbit;
    } bit_evt_t;

    // Running summary of the frame being received.
    typedef struct packed {
        logic seen;
        logic first;
        logic ok;
    } frame_acc_t;

    // Result of a completed frame, valid when done is high.
    typedef struct packed {
        logic done;
        logic quiet;
        logic level;
    } frame_res_t;

    function automatic int unsigned sat_step(input int unsigned v, input int unsigned lim);
        return (v >= lim) ? lim : v + 1;
    endfunction

endpackage

// File: rtl/zmute_sync.sv
module zmute_sync
    import zmute_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     sclk_i,
    input  logic     lrck_i,
    input  logic     sdata_i,
    output bit_evt_t evt
);
    localparam int NSIG = 3;
    localparam int I_SCLK = 2;
    localparam int I_LRCK = 1;
    localparam int I_DATA = 0;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] tapped;
    logic            sclk_d;

    assign raw = {sclk_i, lrck_i, sdata_i};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            chain <= {chain[SYNC_STAGES-2:0], raw[g]};
        end
        assign tapped[g] = chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        sclk_d <= tapped[I_SCLK];
    end

    always_comb begin
        evt.stb  = tapped[I_SCLK] & ~sclk_d;
        evt.lrck = tapped[I_LRCK];
        evt.dbit = tapped[I_DATA];
    end

endmodule

// File: rtl/zmute_frame_trk.sv
module zmute_frame_trk
    import zmute_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bit_evt_t   evt,
    output frame_res_t res
);
    frame_acc_t acc_q, acc_d;
    logic       lrck_last;
    logic       boundary;

    always_comb begin
        boundary  = evt.stb & evt.lrck & ~lrck_last;
        res.done  = boundary;
        res.quiet = acc_q.seen & acc_q.ok;
        res.level = acc_q.first;

        acc_d = acc_q;
        if (evt.stb) begin
            if (boundary || !acc_q.seen) begin
                acc_d.seen  = 1'b1;
                acc_d.first = evt.dbit;
                acc_d.ok    = 1'b1;
            end else begin
                acc_d.ok = acc_q.ok & (evt.dbit == acc_q.first);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            lrck_last <= 1'b0;
        end else if (evt.stb) begin
            acc_q     <= acc_d;
            lrck_last <= evt.lrck;
        end
    end

    // R11
    single_done_chk: assert property (@(posedge clk) disable iff (rst)
        res.done |=> !res.done);

endmodule

// File: rtl/zmute_run_cnt.sv
module zmute_run_cnt
    import zmute_pkg::*;
#(
    parameter int MUTE_FRAMES = 8192
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_stb,
    input  logic       dbit,
    input  frame_res_t res,
    input  logic       auto_en_n,
    output logic       auto_mute
);
    localparam int CNT_W = $clog2(MUTE_FRAMES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MUTE_FRAMES);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             run_q, run_d;

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (bit_stb) begin
            if (res.done) begin
                if (res.quiet) begin
                    if (cnt_q != '0 && res.level == run_q)
                        cnt_d = CNT_W'(sat_step(32'(cnt_q), MUTE_FRAMES));
                    else
                        cnt_d = CNT_W'(1);
                    run_d = res.level;
                end else begin
                    cnt_d = '0;
                end
            end
            if (cnt_d != '0 && dbit != run_d)
                cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end

    assign auto_mute = (cnt_q == LIMIT) & ~auto_en_n;

    // R9
    cnt_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);

    // R11
    cnt_idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_stb |=> $stable(cnt_q));

    // R5
    stray_bit_release_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LIMIT && bit_stb && dbit != run_q) |=> cnt_q == '0);

endmodule

// File: rtl/zero_mute_ctrl.sv
module zero_mute_ctrl
    import zmute_pkg::*;
#(
    parameter int MUTE_FRAMES = 8192,
    parameter int SYNC_STAGES = 2
) (
    input  logic mclk,
    input  logic rst,
    input  logic sclk,
    input  logic lrck,
    input  logic sdata,
    input  logic auto_en_n,
    input  logic mute_l_n,
    input  logic mute_r_n,
    output logic mute_l,
    output logic mute_r
);
    bit_evt_t   evt;
    frame_res_t res;
    logic       auto_mute;

    zmute_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (mclk),
        .sclk_i  (sclk),
        .lrck_i  (lrck),
        .sdata_i (sdata),
        .evt     (evt)
    );

    zmute_frame_trk u_trk (
        .clk (mclk),
        .rst (rst),
        .evt (evt),
        .res (res)
    );

    zmute_run_cnt #(.MUTE_FRAMES(MUTE_FRAMES)) u_cnt (
        .clk       (mclk),
        .rst       (rst),
        .bit_stb   (evt.stb),
        .dbit      (evt.dbit),
        .res       (res),
        .auto_en_n (auto_en_n),
        .auto_mute (auto_mute)
    );

    always_ff @(posedge mclk) begin
        if (rst) begin
            mute_l <= 1'b0;
            mute_r <= 1'b0;
        end else begin
            mute_l <= auto_mute | ~mute_l_n;
            mute_r <= auto_mute | ~mute_r_n;
        end
    end

    // R4
    auto_gate_l_chk: assert property (@(posedge mclk) disable iff (rst)
        (auto_en_n && mute_l_n) |=> !mute_l);

    // R7
    manual_left_chk: assert property (@(posedge mclk) disable iff (rst)
        !mute_l_n |=> mute_l);

    // R8
    manual_right_chk: assert property (@(posedge mclk) disable iff (rst)
        !mute_r_n |=> mute_r);

endmodule

// File: tb/zero_mute_ctrl_bench.sv
module zero_mute_ctrl_bench;
    localparam int TH   = 16;
    localparam int BITS = 4;
    localparam int FB   = 2 * BITS;

    logic mclk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
    logic auto_en_n = 1'b0, mute_l_n = 1'b1, mute_r_n = 1'b1;
    logic mute_l, mute_r;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #2 mclk = ~mclk;

    zero_mute_ctrl #(.MUTE_FRAMES(TH), .SYNC_STAGES(2)) u_zero_mute_ctrl (
        .mclk(mclk), .rst(rst), .sclk(sclk), .lrck(lrck), .sdata(sdata),
        .auto_en_n(auto_en_n), .mute_l_n(mute_l_n), .mute_r_n(mute_r_n),
        .mute_l(mute_l), .mute_r(mute_r)
    );

    // Behavioural reference: input history queue plus integer run state.
    logic [2:0] hist[$];
    int  m_cnt = 0;
    bit  m_run = 0, m_seen = 0, m_first = 0, m_ok = 0, m_lrlast = 0;
    bit  exp_l = 0, exp_r = 0;

    always @(posedge mclk) begin
        logic [2:0] s2, s3;
        bit b, bnd;
        hist.push_back({sclk, lrck, sdata});
        if (hist.size() > 8) void'(hist.pop_front());
        if (rst) begin
            exp_l = 0; exp_r = 0;
            m_cnt = 0; m_run = 0; m_seen = 0; m_first = 0; m_ok = 0; m_lrlast = 0;
        end else begin
            exp_l = ((m_cnt == TH) && !auto_en_n) || !mute_l_n;
            exp_r = ((m_cnt == TH) && !auto_en_n) || !mute_r_n;
            if (hist.size() >= 4) begin
                s2 = hist[hist.size()-3];
                s3 = hist[hist.size()-4];
                if (s2[2] && !s3[2]) begin
                    b   = s2[0];
                    bnd = s2[1] && !m_lrlast;
                    m_lrlast = s2[1];
                    if (bnd) begin
                        if (m_seen && m_ok) begin
                            if (m_cnt > 0 && m_first == m_run)
                                m_cnt = (m_cnt >= TH) ? TH : m_cnt + 1;
                            else
                                m_cnt = 1;
                            m_run = m_first;
                        end else begin
                            m_cnt = 0;
                        end
                    end
                    if (m_cnt > 0 && b != m_run) m_cnt = 0;
                    if (bnd || !m_seen) begin
                        m_seen = 1; m_first = b; m_ok = 1;
                    end else begin
                        m_ok = m_ok && (b == m_first);
                    end
                end
            end
        end
    end

    // R11: cycle-by-cycle comparison against the reference
    always @(negedge mclk) begin
        if (cmp_en) begin
            checks++;
            if (mute_l !== exp_l || mute_r !== exp_r) begin
                errors++;
                $display("FAIL R11 model at %0t: actual l=%b r=%b expected l=%b r=%b",
                         $time, mute_l, mute_r, exp_l, exp_r);
            end
        end
    end

    task automatic chk(input logic act_l, input logic act_r,
                       input logic e_l, input logic e_r, input string tag);
        checks++;
        if (act_l !== e_l || act_r !== e_r) begin
            errors++;
            $display("FAIL %s: actual l=%b r=%b expected l=%b r=%b",
                     tag, act_l, act_r, e_l, e_r);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge mclk);
    endtask

    task automatic do_reset();
        @(negedge mclk);
        rst = 1'b1; sclk = 1'b0; lrck = 1'b0; sdata = 1'b0;
        repeat (4) @(negedge mclk);
        rst = 1'b0;
        cmp_en = 1'b1;
    endtask

    // First half (lrck high) then second half, MSB of pattern first.
    task automatic send_frames(input logic [FB-1:0] pat, input int n);
        for (int f = 0; f < n; f++) begin
            for (int i = FB - 1; i >= 0; i--) begin
                @(negedge mclk);
                sclk = 1'b0; sdata = pat[i]; lrck = (i >= BITS);
                @(negedge mclk);
                @(negedge mclk);
                sclk = 1'b1;
                @(negedge mclk);
            end
        end
    endtask

    initial begin
        do_reset();
        settle();
        chk(mute_l, mute_r, 1'b0, 1'b0, "R1 after reset");

        // R2 threshold boundary on zeros
        send_frames('0, TH);
        settle();
        chk(mute_l, mute_r, 1'b0, 1'b0, "R2 one frame short");
        send_frames('0, 1);
        settle();
        chk(mute_l, mute_r, 1'b1, 1'b1, "R2 threshold reached");

        // R9 saturation over a long run
        send_frames('0, 2 * TH);
        settle();
        chk(mute_l, mute_r, 1'b1, 1'b1, "R9 long run stays muted");

        // R5 single stray bit mid-frame releases
        send_frames(8'h10, 1);
        settle();
        chk(mute_l, mute_r, 1'b0, 1'b0, "R5 stray bit released");

        // R1 reset clears a live mute
        send_frames('0, TH + 2);
        settle();
        chk(mute_l, mute_r, 1'b1, 1'b1, "R1 precondition muted");
        @(negedge mclk); rst = 1'b1;
        repeat (3) @(negedge mclk);
        chk(mute_l, mute_r, 1'b0, 1'b0, "R1 during reset");
        rst = 1'b0;
        settle();
        chk(mute_l, mute_r, 1'b0, 1'b0, "R1 count cleared");

        // R3 all-ones run
        do_reset();
        send_frames('1, TH + 1);
        settle();
        chk(mute_l, mute_r, 1'b1, 1'b1, "R3 ones run mutes");

        // R6 level switch restarts the run
        do_reset();
        send_frames('0, TH / 2);
        send_frames('1, TH);
        settle();
        chk(mute_l, mute_r, 1'b0, 1'b0, "R6 restarted run short");
        send_frames('1, 1);
        settle();
        chk(mute_l, mute_r, 1'b1, 1'b1, "R6 restarted run complete");

        // R10 halves at different levels never qualify
        do_reset();
        send_frames(8'h0F, TH + 2);
        settle();
        chk(mute_l, mute_r, 1'b0, 1'b0, "R10 split frames");

        // R4 enable gating
        do_reset();
        auto_en_n = 1'b1;
        send_frames('0, TH + 3);
        settle();
        chk(mute_l, mute_r, 1'b0, 1'b0, "R4 disabled stays low");
        @(negedge mclk); auto_en_n = 1'b0;
        @(negedge mclk);
        chk(mute_l, mute_r, 1'b1, 1'b1, "R4 enable raises at once");
        auto_en_n = 1'b1;
        @(negedge mclk);
        chk(mute_l, mute_r, 1'b0, 1'b0, "R4 disable clears at once");
        auto_en_n = 1'b0;

        // R7 / R8 manual mutes per channel
        do_reset();
        settle();
        mute_l_n = 1'b0;
        @(negedge mclk);
        chk(mute_l, mute_r, 1'b1, 1'b0, "R7 left manual only");
        mute_l_n = 1'b1; mute_r_n = 1'b0;
        @(negedge mclk);
        chk(mute_l, mute_r, 1'b0, 1'b1, "R8 right manual only");
        mute_r_n = 1'b1;
        settle();
        chk(mute_l, mute_r, 1'b0, 1'b0, "R7 R8 released");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge mclk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule